// File: doc/BRIEF.md
# Video DRAM Address Mapper and Multiplexer

This block forms the address and strobe pins of a frame-buffer memory built from six 16k x 4 DRAMs. The DRAMs are grouped into three byte-wide banks. Each bank has a low-nibble chip and a high-nibble chip that share every strobe. There are two address sources. The video scan counters give a 14-bit address. The CPU gives a 16-bit linear address, in which the visible 320 x 256 picture is laid out column-major.

The CPU address goes through a 512-entry by 8-bit horizontal translate table. The table itself sits outside this block and is read through a combinational index/data port. The table returns a 6-bit horizontal offset and a 2-bit bank number. These are packed with the CPU's low byte into a 16-bit DRAM location. The location is ordered so that the row holds the horizontal offset and the two low vertical bits. This ordering lets normal video scan-out also refresh the DRAMs.

A 2-bit multiplexer phase comes from the external timing sequencer. It picks which of four address groups drives the 8-bit DRAM address bus. The sequencer's row strobe, column strobe and write request are steered to the banks. All DRAM-side outputs are registered and change one clock after their inputs. There is no flow control at the block's edge: the sequencer owns every cycle, so nothing is ever held back.

Top module: `vdram_addr_mux`

## Requirements
- R1: The table index output equals {cpu_addr[15:13], 1'b0, cpu_addr[12:8]}. Bit 5 of the index is always 0. The index is combinational from cpu_addr.
- R2: In phase 0 (mux_sel = 0), dram_addr equals vid_addr[7:0] one clock after the inputs are presented.
- R3: In phase 1, dram_addr equals {1'b1, vid_addr[13:8], vid_addr[13]} one clock later.
- R4: In phase 2, dram_addr equals {cpu_addr[1:0], tbl_data[5:0]} one clock later. This is the row: the two low vertical bits above the horizontal offset.
- R5: In phase 3, dram_addr equals {1'b1, cpu_addr[7:2], cpu_addr[7]} one clock later. This is the column: the upper six vertical bits.
- R6: In CPU phases (mux_sel[1] = 1), bank = tbl_data[7:6]. Bank 0, 1 or 2 receives the row and column strobes on bit 0, 1 or 2 of ras_o/cas_o/we_o. Bank value 3 drives no strobe at all.
- R7: In video phases (mux_sel[1] = 0), the row and column strobes reach all three banks, and no write enable is driven.
- R8: A write request whose cpu_addr[15:14] is 2'b11 drives no write enable in any bank. The row and column strobes still follow R6.
- R9: While rst_n is low, dram_addr, ras_o, cas_o and we_o are all zero. All strobe outputs are active high.
- R10: At most one bank's write enable is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU linear frame-buffer address |
| vid_addr | input | 14 | Video scan counter address |
| mux_sel | input | 2 | Address phase from the timing sequencer |
| seq_ras | input | 1 | Row strobe request |
| seq_cas | input | 1 | Column strobe request |
| seq_we | input | 1 | CPU write request |
| tbl_idx | output | 9 | Translate table read index |
| tbl_data | input | 8 | Translate table read data |
| dram_addr | output | 8 | Registered multiplexed DRAM address |
| ras_o | output | 3 | Registered row strobe per bank |
| cas_o | output | 3 | Registered column strobe per bank |
| we_o | output | 3 | Registered write enable per bank |

## Verification
Two decisions can land in the same cycle: bank steering from the table and write blocking from the upper address bits. When both apply, they disagree about whether a bank sees a write. To provoke this, the bench loads table entries for addresses with both top bits set so that they name a real bank, then issues writes there in CPU phases. The case is judged correct when the named bank still gets its row and column strobes and every write enable stays low. A second overlap comes from video phases with a pending write request: the strobes must fan out to every bank while the write stays suppressed.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
  localparam int CPU_AW = 16;
  localparam int VID_AW = 14;
  localparam int MA_W   = 8;
  localparam int NBANK  = 3;
  localparam int TBL_AW = 9;
  localparam int TBL_DW = 8;
  localparam int H_W    = 6;
  localparam int BK_W   = 2;

  typedef enum logic [1:0] {
    PH_VID_ROW = 2'd0,
    PH_VID_COL = 2'd1,
    PH_CPU_ROW = 2'd2,
    PH_CPU_COL = 2'd3
  } phase_e;

  // Packed DRAM location: bank, low vertical, horizontal, high vertical
  typedef struct packed {
    logic [BK_W-1:0] bank;
    logic [1:0]      vlo;
    logic [H_W-1:0]  h;
    logic [5:0]      vhi;
  } dloc_t;
endpackage

// File: rtl/vdm_xlate.sv
module vdm_xlate
  import vdm_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int TAW = TBL_AW,
  parameter int TDW = TBL_DW
) (
  input  logic [AW-1:0]  cpu_addr,
  input  logic [TDW-1:0] tbl_data,
  output logic [TAW-1:0] tbl_idx,
  output dloc_t          loc,
  output logic           wr_block
);
  localparam int HI_TOP = AW - 1;
  localparam int LOW_FIELD = TAW - 4;

  // Index: top three address bits, a fixed zero, then five page bits
  always_comb begin
    tbl_idx = '0;
    tbl_idx[TAW-1 -: 3] = cpu_addr[HI_TOP -: 3];
    tbl_idx[LOW_FIELD]  = 1'b0;
    tbl_idx[LOW_FIELD-1:0] = cpu_addr[HI_TOP-3 -: LOW_FIELD];
  end

  always_comb begin
    loc.bank = tbl_data[TDW-1 -: BK_W];
    loc.h    = tbl_data[H_W-1:0];
    loc.vlo  = cpu_addr[1:0];
    loc.vhi  = cpu_addr[7:2];
  end

  // Top quarter of the CPU space never writes the frame buffer
  assign wr_block = &cpu_addr[HI_TOP -: 2];
endmodule

// File: rtl/vdm_mux.sv
module vdm_mux
  import vdm_pkg::*;
#(
  parameter int VW = VID_AW,
  parameter int MW = MA_W
) (
  input  logic [1:0]    sel,
  input  logic [VW-1:0] vid_addr,
  input  dloc_t         loc,
  output logic [MW-1:0] ma
);
  localparam int NPH = 4;
  logic [MW-1:0] cand [NPH];

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      if (p == int'(PH_VID_ROW)) begin : g_vr
        assign cand[p] = vid_addr[MW-1:0];
      end else if (p == int'(PH_VID_COL)) begin : g_vc
        assign cand[p] = {1'b1, vid_addr[VW-1 -: MW-2], vid_addr[VW-1]};
      end else if (p == int'(PH_CPU_ROW)) begin : g_cr
        assign cand[p] = {loc.vlo, loc.h};
      end else begin : g_cc
        assign cand[p] = {1'b1, loc.vhi, loc.vhi[5]};
      end
    end
  endgenerate

  assign ma = cand[sel];
endmodule

// File: rtl/vdm_bank_gate.sv
module vdm_bank_gate
  import vdm_pkg::*;
#(
  parameter int NB = NBANK
) (
  input  logic          cpu_phase,
  input  logic [BK_W-1:0] bank,
  input  logic          wr_block,
  input  logic          seq_ras,
  input  logic          seq_cas,
  input  logic          seq_we,
  output logic [NB-1:0] ras,
  output logic [NB-1:0] cas,
  output logic [NB-1:0] we
);
  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit;
      logic cpu_hit;
      assign cpu_hit = (bank == BK_W'(b));
      assign hit     = cpu_phase ? cpu_hit : 1'b1;
      assign ras[b]  = seq_ras & hit;
      assign cas[b]  = seq_cas & hit;
      assign we[b]   = seq_we & cpu_phase & cpu_hit & ~wr_block;
    end
  endgenerate
endmodule

// File: rtl/vdram_addr_mux.sv
module vdram_addr_mux
  import vdm_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int VW  = VID_AW,
  parameter int MW  = MA_W,
  parameter int NB  = NBANK,
  parameter int TAW = TBL_AW,
  parameter int TDW = TBL_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [VW-1:0]  vid_addr,
  input  logic [1:0]     mux_sel,
  input  logic           seq_ras,
  input  logic           seq_cas,
  input  logic           seq_we,
  output logic [TAW-1:0] tbl_idx,
  input  logic [TDW-1:0] tbl_data,
  output logic [MW-1:0]  dram_addr,
  output logic [NB-1:0]  ras_o,
  output logic [NB-1:0]  cas_o,
  output logic [NB-1:0]  we_o
);
  dloc_t         loc;
  logic          wr_block;
  logic [MW-1:0] ma_d;
  logic [NB-1:0] ras_d, cas_d, we_d;

  vdm_xlate #(.AW(AW), .TAW(TAW), .TDW(TDW)) u_xlate (
    .cpu_addr (cpu_addr),
    .tbl_data (tbl_data),
    .tbl_idx  (tbl_idx),
    .loc      (loc),
    .wr_block (wr_block)
  );

  vdm_mux #(.VW(VW), .MW(MW)) u_mux (
    .sel      (mux_sel),
    .vid_addr (vid_addr),
    .loc      (loc),
    .ma       (ma_d)
  );

  vdm_bank_gate #(.NB(NB)) u_gate (
    .cpu_phase (mux_sel[1]),
    .bank      (loc.bank),
    .wr_block  (wr_block),
    .seq_ras   (seq_ras),
    .seq_cas   (seq_cas),
    .seq_we    (seq_we),
    .ras       (ras_d),
    .cas       (cas_d),
    .we        (we_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_addr <= '0;
      ras_o     <= '0;
      cas_o     <= '0;
      we_o      <= '0;
    end else begin
      dram_addr <= ma_d;
      ras_o     <= ras_d;
      cas_o     <= cas_d;
      we_o      <= we_d;
    end
  end
endmodule

// File: rtl/vdram_addr_mux_chk.sv
module vdram_addr_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [13:0] vid_addr,
  input logic [1:0]  mux_sel,
  input logic        seq_we,
  input logic [7:0]  tbl_data,
  input logic [7:0]  dram_addr,
  input logic [2:0]  ras_o,
  input logic [2:0]  cas_o,
  input logic [2:0]  we_o
);
  a_r2_video_row: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 2'd0) |=> (dram_addr == $past(vid_addr[7:0])));

  a_r3_video_col: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 2'd1) |=> (dram_addr == {1'b1, $past(vid_addr[13:8]), $past(vid_addr[13])}));

  a_r5_cpu_col: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 2'd3) |=> (dram_addr == {1'b1, $past(cpu_addr[7:2]), $past(cpu_addr[7])}));

  a_r6_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel[1] && tbl_data[7:6] == 2'b11) |=> (ras_o == 3'b0 && cas_o == 3'b0 && we_o == 3'b0));

  a_r7_video_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_sel[1]) |=> (we_o == 3'b0));

  a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && cpu_addr[15:14] == 2'b11) |=> (we_o == 3'b0));

  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_o));
endmodule

bind vdram_addr_mux vdram_addr_mux_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .vid_addr  (vid_addr),
  .mux_sel   (mux_sel),
  .seq_we    (seq_we),
  .tbl_data  (tbl_data),
  .dram_addr (dram_addr),
  .ras_o     (ras_o),
  .cas_o     (cas_o),
  .we_o      (we_o)
);

// File: tb/vdram_addr_mux_tb.sv
module vdram_addr_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [13:0] vid_addr = '0;
  logic [1:0]  mux_sel = '0;
  logic        seq_ras = 1'b0, seq_cas = 1'b0, seq_we = 1'b0;
  logic [8:0]  tbl_idx;
  logic [7:0]  tbl_data;
  logic [7:0]  dram_addr;
  logic [2:0]  ras_o, cas_o, we_o;
  logic [7:0]  tbl_mem [512];
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign tbl_data = tbl_mem[tbl_idx];

  vdram_addr_mux u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .vid_addr(vid_addr),
    .mux_sel(mux_sel), .seq_ras(seq_ras), .seq_cas(seq_cas), .seq_we(seq_we),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data), .dram_addr(dram_addr),
    .ras_o(ras_o), .cas_o(cas_o), .we_o(we_o)
  );

  function automatic logic [8:0] f_idx(input logic [15:0] a);
    return {a[15:13], 1'b0, a[12:8]};
  endfunction

  function automatic logic [7:0] f_ma(input logic [1:0] s, input logic [13:0] v,
                                      input logic [15:0] a, input logic [7:0] t);
    case (s)
      2'd0: return v[7:0];
      2'd1: return {1'b1, v[13:8], v[13]};
      2'd2: return {a[1:0], t[5:0]};
      default: return {1'b1, a[7:2], a[7]};
    endcase
  endfunction

  function automatic logic [2:0] f_hit(input logic [1:0] s, input logic [7:0] t);
    if (!s[1]) return 3'b111;
    if (t[7:6] == 2'b11) return 3'b000;
    return 3'(1 << t[7:6]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, wait one edge, check at the next negedge
  task automatic step(input logic [1:0] s, input logic [13:0] v, input logic [15:0] a,
                      input logic r, input logic c, input logic w, input string req);
    logic [7:0] t, ema;
    logic [2:0] hit, ewe;
    mux_sel = s; vid_addr = v; cpu_addr = a; seq_ras = r; seq_cas = c; seq_we = w;
    #0.5;
    chk("R1 table index", 32'(tbl_idx), 32'(f_idx(a)));
    t   = tbl_mem[f_idx(a)];
    ema = f_ma(s, v, a, t);
    hit = f_hit(s, t);
    ewe = (w && s[1] && a[15:14] != 2'b11) ? hit : 3'b000;
    @(posedge clk);
    @(negedge clk);
    chk({req, " addr"}, 32'(dram_addr), 32'(ema));
    chk("R6/R7 ras", 32'(ras_o), 32'(r ? hit : 3'b000));
    chk("R6/R7 cas", 32'(cas_o), 32'(c ? hit : 3'b000));
    chk("R8/R10 we", 32'(we_o), 32'(ewe));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) tbl_mem[i] = 8'($urandom);
    seq_ras = 1'b1; seq_cas = 1'b1; seq_we = 1'b1; mux_sel = 2'd2;
    cpu_addr = 16'h1234; vid_addr = 14'h3fff;
    repeat (3) @(negedge clk);
    chk("R9 reset addr", 32'(dram_addr), 0);
    chk("R9 reset ras", 32'(ras_o), 0);
    chk("R9 reset cas", 32'(cas_o), 0);
    chk("R9 reset we", 32'(we_o), 0);
    rst_n = 1'b1;

    // Directed: each phase (R2 R3 R4 R5)
    step(2'd0, 14'h2a5c, 16'h0000, 1, 0, 1, "R2");
    step(2'd1, 14'h2a5c, 16'h0000, 0, 1, 1, "R3");
    step(2'd1, 14'h1a5c, 16'h0000, 0, 1, 0, "R3");
    step(2'd2, 14'h0000, 16'h4b7e, 1, 0, 1, "R4");
    step(2'd3, 14'h0000, 16'h4b7e, 0, 1, 1, "R5");
    step(2'd3, 14'h0000, 16'h4b02, 0, 1, 1, "R5");
    // R6: every bank value including 3 (no bank)
    for (int b = 0; b < 4; b++) begin
      tbl_mem[f_idx(16'h2300)] = {2'(b), 6'h15};
      step(2'd2, 14'h0, 16'h2300, 1, 1, 1, "R6");
    end
    // R8 with R6 overlap: blocked region names a real bank
    tbl_mem[f_idx(16'hc400)] = 8'h4a;
    step(2'd2, 14'h0, 16'hc400, 1, 1, 1, "R8");
    step(2'd3, 14'h0, 16'hc7ff, 1, 1, 1, "R8");
    tbl_mem[f_idx(16'hbf00)] = 8'h8c;
    step(2'd3, 14'h0, 16'hbf00, 1, 1, 1, "R8 edge");
    // R7: video phase with pending write
    step(2'd0, 14'h0123, 16'h2300, 1, 1, 1, "R7");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      step(2'($urandom), 14'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), "R2-5 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule